// File: doc/BRIEF.md
# Prioritised Interrupt Offset Unit

This block gathers the interrupt status of a two-channel checking engine and combines it into a single interrupt request. Each channel has five kinds of event: check failure, job done, overrun, underrun and timeout. Each event has a sticky status flag and an enable bit. A read-only offset register reports the most urgent pending, enabled event as a sparse fixed code. Reading that register in normal operation also clears the flag it reports. An interrupt handler can therefore drain every pending cause by reading the offset register repeatedly until it returns zero.

Two per-channel watchdog counters produce the timeout events. A data event on a channel reloads its counter from a programmable preload value. While the channel is marked active, the counter counts down, and it raises the timeout flag when it reaches zero. A debug suspend input freezes both counters. While suspend is high, a register read returns contents only and has no side effect, so a debugger can inspect the offset register without disturbing state.

Top module: `irq_offset_unit`

## Requirements
- R1: `irq` is high exactly when at least one status flag is set and its enable bit (register 1, same bit layout as status) is also set.
- R2: Status bit `2*g+ch` (ch 0 or 1) belongs to group g: 0 fail, 1 done, 2 overrun, 3 underrun, 4 timeout. The offset code for that flag is `8*g+ch+1`, giving 01h, 02h, 09h, 0Ah, 11h, 12h, 19h, 1Ah, 21h, 22h. No other code is ever produced.
- R3: Offset register (address 2) returns the code of the pending enabled flag with the smallest code, or 0 when none is pending.
- R4: Read data appears on `reg_rdata` one cycle after the read is accepted. An offset read with `suspend` low clears the flag it reports at that same clock edge.
- R5: While `suspend` is high, no read changes any status flag.
- R6: Writing 1 to a bit of the status register (address 0) clears that flag. A set pulse in the same cycle as a clear leaves the flag set.
- R7: A data event on channel ch loads that channel's counter from its preload register (address 4+ch). While active bit ch (address 3) is set, the counter decrements once per cycle. The timeout flag is set at the edge where the counter goes from 1 to 0.
- R8: While `suspend` is high, both timeout counters hold their value.
- R9: Addresses 6 and above read as zero, and writes to them and to the offset register change nothing.
- R10: After reset all registers read zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| set_fail | input | 2 | Per-channel check-failure set pulse |
| set_done | input | 2 | Per-channel job-done set pulse |
| set_ovr | input | 2 | Per-channel overrun set pulse |
| set_udr | input | 2 | Per-channel underrun set pulse |
| data_evt | input | 2 | Per-channel data event, reloads the timeout counter |
| suspend | input | 1 | Debug suspend: reads have no side effect, counters freeze |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that the strobes and pulses are clean single-cycle levels sampled at the clock edge, and that a status write and an offset read in the same cycle are rare. The suspend-read property is qualified so that it excludes a concurrent status write. The bench drives every input at the falling edge and raises each strobe for exactly one cycle. It writes status only to clear it between vectors, and changes suspend only between accesses, so each property sees the input patterns it presumes.

// File: rtl/iou_pkg.sv
package iou_pkg;
    localparam int NCH        = 2;
    localparam int NGRP       = 5;
    localparam int NSRC       = NCH * NGRP;
    localparam int GRP_STRIDE = 8;
    localparam int CODE_W     = 8;

    localparam int A_STATUS = 0;
    localparam int A_ENABLE = 1;
    localparam int A_OFFSET = 2;
    localparam int A_ACTIVE = 3;
    localparam int A_PRE0   = 4;

    // flag index -> sparse offset code
    function automatic logic [CODE_W-1:0] src_code(input int idx);
        return CODE_W'((idx / NCH) * GRP_STRIDE + (idx % NCH) + 1);
    endfunction
endpackage

// File: rtl/iou_prio_enc.sv
module iou_prio_enc
    import iou_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]      pend,
    output logic [N-1:0]      grant,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        grant = '0;
        code  = '0;
        // walk downward so the lowest index is the last to win
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                code     = src_code(i);
            end
        end
    end
endmodule

// File: rtl/iou_timeout.sv
module iou_timeout #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             active,
    input  logic             suspend,
    input  logic [CNT_W-1:0] preload,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        hit   = 1'b0;
        if (evt) begin
            cnt_d = preload;
        end else if (active && !suspend && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
            hit   = (cnt_q == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: suspend freezes the counter
    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && !evt) |=> $stable(cnt_q));

    // R7: an expired counter stays expired until the next data event
    a_r7_stay_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !evt) |=> (cnt_q == '0));
endmodule

// File: rtl/irq_offset_unit.sv
module irq_offset_unit
    import iou_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NCH-1:0]    set_fail,
    input  logic [NCH-1:0]    set_done,
    input  logic [NCH-1:0]    set_ovr,
    input  logic [NCH-1:0]    set_udr,
    input  logic [NCH-1:0]    data_evt,
    input  logic              suspend,
    output logic              irq
);
    typedef struct packed {
        logic [NSRC-1:0]             status;
        logic [NSRC-1:0]             enable;
        logic [NCH-1:0]              active;
        logic [NCH-1:0][CNT_W-1:0]   preload;
        logic [DATA_W-1:0]           rdata;
    } state_t;

    state_t s_d, s_q;

    logic [NSRC-1:0]   set_vec, pend, grant, clr;
    logic [NCH-1:0]    tmo_hit;
    logic [CODE_W-1:0] code;
    logic              rd_off;

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            iou_timeout #(.CNT_W(CNT_W)) u_tmo (
                .clk     (clk),
                .rst_n   (rst_n),
                .evt     (data_evt[ch]),
                .active  (s_q.active[ch]),
                .suspend (suspend),
                .preload (s_q.preload[ch]),
                .hit     (tmo_hit[ch])
            );
            assign set_vec[0*NCH+ch] = set_fail[ch];
            assign set_vec[1*NCH+ch] = set_done[ch];
            assign set_vec[2*NCH+ch] = set_ovr[ch];
            assign set_vec[3*NCH+ch] = set_udr[ch];
            assign set_vec[4*NCH+ch] = tmo_hit[ch];
        end
        if (DATA_W > CNT_W) begin : g_spare
            logic spare_bits;
            assign spare_bits = ^reg_wdata[DATA_W-1:CNT_W];
        end
    endgenerate

    assign pend = s_q.status & s_q.enable;

    iou_prio_enc #(.N(NSRC)) u_prio (
        .pend  (pend),
        .grant (grant),
        .code  (code)
    );

    assign irq       = |pend;
    assign reg_rdata = s_q.rdata;
    assign rd_off    = reg_rd && (reg_addr == ADDR_W'(A_OFFSET));

    always_comb begin
        s_d = s_q;
        clr = '0;

        if (reg_wr && reg_addr == ADDR_W'(A_STATUS)) clr = clr | reg_wdata[NSRC-1:0];
        if (rd_off && !suspend)                      clr = clr | grant;
        // set pulses take precedence over any clear
        s_d.status = (s_q.status & ~clr) | set_vec;

        if (reg_wr) begin
            if (reg_addr == ADDR_W'(A_ENABLE)) s_d.enable = reg_wdata[NSRC-1:0];
            if (reg_addr == ADDR_W'(A_ACTIVE)) s_d.active = reg_wdata[NCH-1:0];
            for (int ch = 0; ch < NCH; ch++) begin
                if (reg_addr == ADDR_W'(A_PRE0 + ch)) s_d.preload[ch] = reg_wdata[CNT_W-1:0];
            end
        end

        if (reg_rd) begin
            s_d.rdata = '0;
            if (reg_addr == ADDR_W'(A_STATUS)) s_d.rdata = DATA_W'(s_q.status);
            if (reg_addr == ADDR_W'(A_ENABLE)) s_d.rdata = DATA_W'(s_q.enable);
            if (reg_addr == ADDR_W'(A_OFFSET)) s_d.rdata = DATA_W'(code);
            if (reg_addr == ADDR_W'(A_ACTIVE)) s_d.rdata = DATA_W'(s_q.active);
            for (int ch = 0; ch < NCH; ch++) begin
                if (reg_addr == ADDR_W'(A_PRE0 + ch)) s_d.rdata = DATA_W'(s_q.preload[ch]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1/R3: the request and a nonzero offset code go together
    a_r1_irq_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (code != '0));

    // R4: offset read returns the code present when it was accepted
    a_r4_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_off |=> (reg_rdata == DATA_W'($past(code))));

    // R5: a suspended read never drops a flag
    a_r5_suspend_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && suspend && !(reg_wr && reg_addr == ADDR_W'(A_STATUS)))
        |=> ((s_q.status & $past(s_q.status)) == $past(s_q.status)));

    // R6: a set pulse always lands, whatever clears arrive
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((s_q.status & $past(set_vec)) == $past(set_vec)));
endmodule

// File: tb/tb_irq_offset_unit.sv
`timescale 1ns/1ps
module tb_irq_offset_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  set_fail = '0, set_done = '0, set_ovr = '0, set_udr = '0, data_evt = '0;
    logic        suspend = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    irq_offset_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .set_fail(set_fail), .set_done(set_done), .set_ovr(set_ovr),
        .set_udr(set_udr), .data_evt(data_evt), .suspend(suspend), .irq(irq)
    );

    always #2 clk = ~clk;

    // {set pulses [7:0], enable [9:0], expected offset code [7:0]}
    localparam logic [25:0] VEC [12] = '{
        {8'h01, 10'h3FF, 8'h01},
        {8'h02, 10'h3FF, 8'h02},
        {8'hFF, 10'h3FF, 8'h01},
        {8'hFC, 10'h3FF, 8'h09},
        {8'hF0, 10'h3FF, 8'h11},
        {8'hC0, 10'h3FF, 8'h19},
        {8'h80, 10'h3FF, 8'h1A},
        {8'hFF, 10'h0F0, 8'h11},
        {8'hFF, 10'h000, 8'h00},
        {8'h28, 10'h3FF, 8'h0A},
        {8'h60, 10'h040, 8'h19},
        {8'h20, 10'h3FF, 8'h12}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(posedge clk); @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = 4'(a);
        @(posedge clk); @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic pulse(input logic [7:0] s);
        @(negedge clk);
        set_fail = s[1:0]; set_done = s[3:2]; set_ovr = s[5:4]; set_udr = s[7:6];
        @(posedge clk); @(negedge clk);
        set_fail = '0; set_done = '0; set_ovr = '0; set_udr = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10 reset state
        chk("R10 irq", 32'(irq), 0);
        chk("R10 rdata", reg_rdata, 0);
        rd(0, r); chk("R10 status", r, 0);
        rd(1, r); chk("R10 enable", r, 0);
        rd(2, r); chk("R10 offset", r, 0);

        // R1 R2 R3 R4 vector walk
        foreach (VEC[k]) begin
            logic [7:0] s;
            logic [9:0] en, pe, win;
            s = VEC[k][25:18]; en = VEC[k][17:8];
            pe = {2'b00, s} & en;
            win = pe & (~pe + 10'd1);
            wr(0, 32'h3FF);
            wr(1, 32'(en));
            pulse(s);
            chk("R1 irq", 32'(irq), 32'(|pe));
            rd(2, r); chk("R3 offset code", r, 32'(VEC[k][7:0]));
            rd(0, r); chk("R4 read clears winner", r, 32'({2'b00, s} & ~win));
        end

        // R4 draining by repeated reads
        wr(0, 32'h3FF); wr(1, 32'h3FF);
        pulse(8'h41);
        rd(2, r); chk("R4 drain first", r, 32'h01);
        rd(2, r); chk("R4 drain second", r, 32'h19);
        rd(2, r); chk("R4 drain empty", r, 32'h00);
        chk("R1 irq low after drain", 32'(irq), 0);

        // R5 suspended reads keep flags
        pulse(8'h08);
        suspend = 1'b1;
        rd(2, r); chk("R5 suspend read", r, 32'h0A);
        rd(2, r); chk("R5 suspend read again", r, 32'h0A);
        rd(0, r); chk("R5 status kept", r, 32'h08);
        @(negedge clk); suspend = 1'b0;
        rd(2, r); chk("R4 functional read", r, 32'h0A);
        rd(2, r); chk("R4 cleared after read", r, 32'h00);

        // R6 write-one-to-clear and set-wins
        pulse(8'h11);
        wr(0, 32'h010);
        rd(0, r); chk("R6 w1c", r, 32'h001);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h001; set_fail = 2'b01;
        @(posedge clk); @(negedge clk); reg_wr = 1'b0; set_fail = '0;
        rd(0, r); chk("R6 set wins", r, 32'h001);
        wr(0, 32'h3FF);

        // R9 unimplemented and read-only addresses
        pulse(8'h02);
        wr(2, 32'hFFFF);
        wr(9, 32'hFFFF);
        rd(0, r); chk("R9 offset write ignored", r, 32'h002);
        rd(9, r); chk("R9 unimplemented reads zero", r, 0);
        rd(15, r); chk("R9 top address reads zero", r, 0);
        wr(0, 32'h3FF);

        // R7 timeout on channel 0, preload 5
        wr(4, 32'd5); wr(3, 32'h1); wr(1, 32'h100);
        rd(4, r); chk("R7 preload readback", r, 32'd5);
        @(negedge clk); data_evt = 2'b01;
        @(posedge clk); @(negedge clk); data_evt = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); chk("R7 not yet expired", 32'(irq), 0);
        @(posedge clk); @(negedge clk); chk("R7 expired", 32'(irq), 1);
        rd(2, r); chk("R7 timeout code", r, 32'h21);

        // R8 suspend freezes the count for three cycles
        @(negedge clk); data_evt = 2'b01;
        @(posedge clk); @(negedge clk); data_evt = '0; suspend = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); suspend = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk); chk("R8 frozen count not expired", 32'(irq), 0);
        @(posedge clk); @(negedge clk); chk("R8 expires after resume", 32'(irq), 1);
        wr(0, 32'h3FF);

        // R7 inactive channel 1 never times out
        wr(5, 32'd3); wr(3, 32'h0); wr(1, 32'h200);
        @(negedge clk); data_evt = 2'b10;
        @(posedge clk); @(negedge clk); data_evt = '0;
        repeat (10) @(posedge clk);
        @(negedge clk); chk("R7 inactive channel idle", 32'(irq), 0);

        finish_run();
    end
endmodule